// File: doc/BRIEF.md
# Top-of-Space Internal Data RAM Decoder

This block places a small internal data RAM in the highest window of a 16-bit external data address space and decides, for every CPU data access, whether the access is served by that RAM or handed to the external bus interface beside it. Each access lasts two clock cycles. The CPU presents the request in the first cycle. The chosen target (internal RAM or external cycle) is active in the second cycle, and read data comes back in that cycle too.

A map-enable bit decides whether the internal RAM is visible at all. Reset clears the bit. While it is clear, every access goes out on the external bus. While it is set, addresses whose upper byte is all ones hit the internal RAM, and no external cycle is raised for them. An access can use a full 16-bit pointer address. It can also use a short 8-bit register address, whose upper byte comes from a page input.

The RAM array has no reset. A reset that lands in the middle of an internal write either drops the write or lets it complete, depending on which of the two cycles the reset is sampled in.

Top module: `xwin_ctrl`

## Requirements
- R1: Reset clears the map-enable bit. The first access after reset goes to the external bus even inside the top window.
- R2: With the map enabled, an access whose effective address lies in FF00h–FFFFh asserts `int_sel` in its second cycle and does not assert `ext_req`.
- R3: With the map enabled, an access whose effective address lies in 0000h–FEFFh asserts `ext_req` in its second cycle. `ext_addr` carries the effective address, and `ext_we` equals the request's write flag.
- R4: With the map disabled, every access asserts `ext_req` and never `int_sel`. This holds for every address and for both address modes.
- R5: When `req_short` is 1, the effective address is {`req_page`, `req_addr[7:0]`}. It is decoded in the same way as a 16-bit address.
- R6: For a read, `rsp_valid` is high for exactly the second cycle, and `rsp_data` is valid in that cycle. An internal write is stored at the clock edge that ends the second cycle.
- R7: If `rst_n` is low at the edge that ends the first cycle of an internal write, the RAM location keeps its old value.
- R8: If `rst_n` is low at the edge that ends the second cycle of an internal write, the new value is stored.
- R9: Reset does not change the RAM contents.
- R10: `ext_req` and `int_sel` are never high in the same cycle.
- R11: A request presented during the second cycle of an access is ignored. No access starts from it.
- R12: A pulse on `en_wr` loads `en_val` into the map-enable bit, which takes effect from the next access. Clearing the bit hides the RAM without altering its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Load strobe for the map-enable bit |
| en_val | input | 1 | Value loaded into the map-enable bit |
| req_valid | input | 1 | Access request, first cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = 8-bit register address mode |
| req_addr | input | 16 | Pointer address; only bits 7:0 are used in short mode |
| req_page | input | 8 | Upper address byte used in short mode |
| req_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the external bus, second cycle |
| rsp_valid | output | 1 | Read data valid, second cycle |
| rsp_data | output | 8 | Read data |
| ext_req | output | 1 | External bus cycle request, second cycle |
| ext_we | output | 1 | External cycle is a write |
| ext_addr | output | 16 | External cycle address |
| ext_wdata | output | 8 | External write data |
| int_sel | output | 1 | Internal RAM selected, second cycle |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. They also assume that `req_valid` is raised only while the block is idle, except when an overlap is deliberately tested. Both assumptions are needed for the phase and pulse checks to hold from time zero. The bench holds reset from time zero and drives every input at the falling edge. It starts a new access only after the previous one has returned to idle. The R11 case is the one exception: there, a request is held into the second cycle on purpose. Reads of the internal RAM are made only from locations the bench has already written, because the array powers up undefined.

// File: rtl/xwin_pkg.sv
// Shared types for the internal data RAM decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package xwin_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,   // waiting for a request
        PH_DATA = 1'b1    // second cycle of an accepted access
    } phase_e;
endpackage

// File: rtl/xwin_decode.sv
// Address decoder: builds the effective address from either mode and
// flags whether it falls in the internal window at the top of the space.
// Assumes: the window is the top 2**LOW_W addresses; purely combinational.
module xwin_decode #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 8,
    localparam int PAGE_W = ADDR_W - LOW_W
) (
    input  logic              map_en,
    input  logic              short_mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [PAGE_W-1:0] page_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              hit_int
);
    // form effective address and window hit
    always_comb begin
        eff_addr = short_mode ? {page_in, addr_in[LOW_W-1:0]} : addr_in;
        hit_int  = map_en && (&eff_addr[ADDR_W-1:LOW_W]);
    end
endmodule

// File: rtl/xwin_ram.sv
// Internal data RAM: one write port, one combinational read port.
// Assumes: no reset on the array, so contents persist across reset.
module xwin_ram #(
    parameter int DATA_W = 8,
    parameter int LOW_W  = 8,
    localparam int DEPTH = 1 << LOW_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LOW_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // store write data; deliberately independent of reset
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // return the addressed word
    always_comb rdata = mem[addr];
endmodule

// File: rtl/xwin_seq.sv
// Access sequencer: accepts a request while idle, holds it for the
// second cycle and produces the RAM write strobe in that cycle only.
// Assumes: synchronous active-low reset; the write strobe comes from
// registered state, so a reset at the end of cycle two cannot stop it.
module xwin_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              hit_int,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              in_data,
    output logic              cur_we,
    output logic              cur_hit,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              ram_we
);
    import xwin_pkg::*;

    phase_e phase_q;
    logic   accept;

    // a request is taken only while idle
    always_comb accept = (phase_q == PH_IDLE) && req_valid;

    // phase register: one data cycle per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= PH_IDLE;
        else if (accept) phase_q <= PH_DATA;
        else             phase_q <= PH_IDLE;
    end

    // capture the decoded access at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_we    <= 1'b0;
            cur_hit   <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else if (accept) begin
            cur_we    <= req_we;
            cur_hit   <= hit_int;
            cur_addr  <= eff_addr;
            cur_wdata <= req_wdata;
        end
    end

    // second-cycle indicators
    always_comb begin
        in_data = (phase_q == PH_DATA);
        ram_we  = in_data && cur_we && cur_hit;
    end

    // R11: the data cycle is always followed by idle, whatever is requested
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |=> !in_data);

    // R6: RAM is written only in the cycle after an acceptance
    p_wstb_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(accept));
endmodule

// File: rtl/xwin_ctrl.sv
// Top of the internal data RAM decoder. Holds the map-enable bit, routes
// each two-cycle access to the internal RAM or to the external bus, and
// muxes read data back.
// Assumes: synchronous active-low reset; external read data is valid in
// the second cycle of an external read.
module xwin_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LOW_W  = 8,
    localparam int PAGE_W = ADDR_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              req_short,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ext_req,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              int_sel
);
    logic              map_en;
    logic [ADDR_W-1:0] eff_addr;
    logic              hit_int;
    logic              in_data;
    logic              cur_we;
    logic              cur_hit;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    // map-enable bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     map_en <= 1'b0;
        else if (en_wr) map_en <= en_val;
    end

    xwin_decode #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_decode (
        .map_en     (map_en),
        .short_mode (req_short),
        .addr_in    (req_addr),
        .page_in    (req_page),
        .eff_addr   (eff_addr),
        .hit_int    (hit_int)
    );

    xwin_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .eff_addr  (eff_addr),
        .hit_int   (hit_int),
        .req_wdata (req_wdata),
        .in_data   (in_data),
        .cur_we    (cur_we),
        .cur_hit   (cur_hit),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .ram_we    (ram_we)
    );

    xwin_ram #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (cur_addr[LOW_W-1:0]),
        .wdata (cur_wdata),
        .rdata (ram_rdata)
    );

    // steer the second cycle to one target and return read data
    always_comb begin
        int_sel   = in_data && cur_hit;
        ext_req   = in_data && !cur_hit;
        ext_we    = ext_req && cur_we;
        ext_addr  = cur_addr;
        ext_wdata = cur_wdata;
        rsp_valid = in_data && !cur_we;
        rsp_data  = cur_hit ? ram_rdata : ext_rdata;
    end

    // R10: never both targets at once
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_req && int_sel));

    // R2: internal selection only for addresses in the top window
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_sel |-> (&ext_addr[ADDR_W-1:LOW_W]));

    // R1: enable is clear right after reset is released
    p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !map_en);

    // R6: read response is a single-cycle pulse
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/xwin_ctrl_tb_top.sv
// Self-checking bench: vector table walk, then directed reset/overlap cases.
module xwin_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_wr = 1'b0, en_val = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, req_short = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_page = '0, req_wdata = '0, ext_rdata = '0;
    logic        rsp_valid, ext_req, ext_we, int_sel;
    logic [7:0]  rsp_data, ext_wdata;
    logic [15:0] ext_addr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    xwin_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val),
        .req_valid(req_valid), .req_we(req_we), .req_short(req_short),
        .req_addr(req_addr), .req_page(req_page), .req_wdata(req_wdata),
        .ext_rdata(ext_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .int_sel(int_sel)
    );

    typedef struct packed {
        logic        en;
        logic        we;
        logic        sh;
        logic [15:0] addr;
        logic [7:0]  page;
        logic [7:0]  wd;
        logic [7:0]  xr;
        logic        exp_int;
        logic [7:0]  exp_rd;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,16'hFF10,8'h00,8'h11,8'h00,1'b0,8'h00,4'd4},  // R4 disabled write
        '{1'b0,1'b0,1'b1,16'h0020,8'hFF,8'h00,8'h5A,1'b0,8'h5A,4'd4},  // R4 short mode
        '{1'b1,1'b1,1'b0,16'hFF10,8'h00,8'h3C,8'h00,1'b1,8'h00,4'd2},  // R2 write
        '{1'b1,1'b0,1'b0,16'hFF10,8'h00,8'h00,8'hEE,1'b1,8'h3C,4'd2},  // R2 read
        '{1'b1,1'b0,1'b0,16'hFEFF,8'h00,8'h00,8'h77,1'b0,8'h77,4'd3},  // R3 edge below
        '{1'b1,1'b1,1'b0,16'h0000,8'h00,8'h01,8'h00,1'b0,8'h00,4'd3},  // R3 bottom
        '{1'b1,1'b1,1'b1,16'h1280,8'hFF,8'hC8,8'h00,1'b1,8'h00,4'd5},  // R5 short int
        '{1'b1,1'b0,1'b0,16'hFF80,8'h00,8'h00,8'h00,1'b1,8'hC8,4'd5},  // R5 cross check
        '{1'b1,1'b0,1'b1,16'hFF80,8'h12,8'h00,8'h9A,1'b0,8'h9A,4'd5},  // R5 short ext
        '{1'b1,1'b1,1'b0,16'hFFFF,8'h00,8'hE1,8'h00,1'b1,8'h00,4'd2},  // R2 top
        '{1'b1,1'b0,1'b0,16'hFFFF,8'h00,8'h00,8'h00,1'b1,8'hE1,4'd2},  // R2 top
        '{1'b1,1'b1,1'b0,16'hFF00,8'h00,8'h0F,8'h00,1'b1,8'h00,4'd2},  // R2 base
        '{1'b1,1'b0,1'b0,16'hFF00,8'h00,8'h00,8'h00,1'b1,8'h0F,4'd2},  // R2 base
        '{1'b0,1'b0,1'b0,16'hFF10,8'h00,8'h00,8'h44,1'b0,8'h44,4'd12}, // R12 cleared
        '{1'b1,1'b0,1'b0,16'hFF10,8'h00,8'h00,8'h00,1'b1,8'h3C,4'd12}  // R12 kept
    };

    // sampled second-cycle outputs
    logic       s_int, s_ext, s_we, s_rv;
    logic [15:0] s_addr;
    logic [7:0]  s_rd, s_wd;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en_wr = 1'b1; en_val = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic access(input logic we, input logic sh, input logic [15:0] a,
                          input logic [7:0] pg, input logic [7:0] wd,
                          input logic [7:0] xr);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_short = sh; req_addr = a;
        req_page = pg; req_wdata = wd; ext_rdata = xr;
        @(negedge clk);
        s_int = int_sel; s_ext = ext_req; s_we = ext_we; s_rv = rsp_valid;
        s_addr = ext_addr; s_rd = rsp_data; s_wd = ext_wdata;
        req_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of outputs
        chk("R1 ext_req idle", int'(ext_req), 0);
        chk("R1 int_sel idle", int'(int_sel), 0);
        chk("R1 rsp_valid idle", int'(rsp_valid), 0);
        // R1 top window goes external right after reset
        access(1'b0, 1'b0, 16'hFF10, 8'h00, 8'h00, 8'h61);
        chk("R1 ext after reset", int'(s_ext), 1);
        chk("R1 no int after reset", int'(s_int), 0);
        chk("R1 ext read data", int'(s_rd), 'h61);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [15:0] ea;
            string tg;
            v = VECS[i];
            tg = $sformatf("R%0d vec%0d", v.rq, i);
            set_en(v.en);
            access(v.we, v.sh, v.addr, v.page, v.wd, v.xr);
            ea = v.sh ? {v.page, v.addr[7:0]} : v.addr;
            chk({tg, " int_sel"}, int'(s_int), int'(v.exp_int));
            chk({tg, " ext_req"}, int'(s_ext), int'(!v.exp_int));
            chk({tg, " R10 exclusive"}, int'(s_int & s_ext), 0);
            if (!v.exp_int) begin
                chk({tg, " ext_addr"}, int'(s_addr), int'(ea));
                chk({tg, " ext_we"}, int'(s_we), int'(v.we));
                if (v.we) chk({tg, " ext_wdata"}, int'(s_wd), int'(v.wd));
            end
            chk({tg, " R6 rsp_valid"}, int'(s_rv), int'(!v.we));
            if (!v.we) chk({tg, " rsp_data"}, int'(s_rd), int'(v.exp_rd));
        end

        // R6 response lasts one cycle
        access(1'b0, 1'b0, 16'hFF10, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        chk("R6 rsp_valid drops", int'(rsp_valid), 0);

        // R7 reset sampled at end of first cycle drops the write
        access(1'b1, 1'b0, 16'hFF30, 8'h00, 8'hAA, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_short = 1'b0;
        req_addr = 16'hFF30; req_wdata = 8'h55; rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b1;
        chk("R7 no access started", int'(int_sel | ext_req), 0);
        set_en(1'b1);
        access(1'b0, 1'b0, 16'hFF30, 8'h00, 8'h00, 8'h00);
        chk("R7 old value kept", int'(s_rd), 'hAA);

        // R8 reset sampled at end of second cycle still stores
        access(1'b1, 1'b0, 16'hFF40, 8'h00, 8'h66, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'hFF40; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b0, 16'hFF40, 8'h00, 8'h00, 8'h13);
        chk("R1 disabled after R8 reset", int'(s_ext), 1);
        set_en(1'b1);
        access(1'b0, 1'b0, 16'hFF40, 8'h00, 8'h00, 8'h00);
        chk("R8 new value stored", int'(s_rd), 'h99);

        // R9 earlier contents survive both resets
        access(1'b0, 1'b0, 16'hFF10, 8'h00, 8'h00, 8'h00);
        chk("R9 contents kept", int'(s_rd), 'h3C);
        pulse_reset();
        set_en(1'b1);
        access(1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00, 8'h00);
        chk("R9 contents kept top", int'(s_rd), 'hE1);

        // R11 request held into the second cycle is ignored
        access(1'b1, 1'b0, 16'hFF50, 8'h00, 8'h12, 8'h00);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 16'hFF10;
        @(negedge clk);
        req_we = 1'b1; req_addr = 16'hFF50; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 no second access", int'(int_sel | ext_req), 0);
        access(1'b0, 1'b0, 16'hFF50, 8'h00, 8'h00, 8'h00);
        chk("R11 write ignored", int'(s_rd), 'h12);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule